// File: doc/BRIEF.md
# Multi-lane alignment checker

This block sits beside the receive elastic buffers of a multi-lane serial link. Lane alignment is watched only while frame synchronization is in its data state. On every lane it waits for the end-of-multi-frame control character (K28.3). It stamps the cycle of the first such character on each lane with a free-running local timestamp.

Once every lane has been seen, the latest of these arrivals becomes the common release point. Each lane's delay is that point minus the lane's own arrival time. The block then raises the buffer release for all lanes. From then on it checks that every later end-of-multi-frame character falls on a multi-frame boundary of its own lane. There are two separate errors: first arrivals that spread wider than one multi-frame, and a misplaced end-of-multi-frame character during user data. The block never realigns. Either error raises a request to reinitialize the link.

The multi-frame length is a runtime input, counted in octets. Each lane delivers one octet per cycle in which its valid strobe is high.

Top module: `lane_align_mon`

## Requirements
- R1: After reset, and in any cycle following one in which `fs_data` was low, every output is 0. End-of-multi-frame characters presented while `fs_data` is low leave no trace.
- R2: An end-of-multi-frame character is an octet of value 8'h7C with its lane's control flag and valid strobe high. The same value with the control flag low is data and is not counted.
- R3: `align_done` and every bit of `buf_rel` rise in the cycle after the clock edge that samples the last lane's first end-of-multi-frame character. They then stay high until `fs_data` falls.
- R4: While `align_done` is high, the field `lane_dly[i*TS_W +: TS_W]` holds the latest first-arrival cycle minus lane i's first-arrival cycle, where TS_W = MF_W + 2. The latest lane therefore shows 0.
- R5: `err_skew` is set if the first arrivals span more than `mf_len` cycles; a span of exactly `mf_len` is accepted. A lane still missing `mf_len`+1 cycles after the first arrival also sets `err_skew`. When `err_skew` is set, `align_done` never rises.
- R6: While `align_done` is high, `err_misalign` is set by an end-of-multi-frame character on any lane whose count of valid octets since that lane's first one is not a multiple of `mf_len`. Repeated characters before `align_done` do not set it.
- R7: `sync_req` is high whenever either error flag is set. Both flags hold until `fs_data` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_octet | input | NUM_LANES*8 | Received octet per lane, lane i at [i*8 +: 8] |
| rx_ctrl | input | NUM_LANES | Control-character flag per lane |
| rx_vld | input | NUM_LANES | Octet valid strobe per lane |
| fs_data | input | 1 | Frame synchronization is in its data state |
| mf_len | input | MF_W | Multi-frame length in octets |
| buf_rel | output | NUM_LANES | Elastic buffer release per lane |
| lane_dly | output | NUM_LANES*TS_W | Per-lane delay to the common release point |
| align_done | output | 1 | Inter-lane alignment established |
| err_skew | output | 1 | First arrivals spread beyond one multi-frame |
| err_misalign | output | 1 | Misplaced end-of-multi-frame in user data |
| sync_req | output | 1 | Link reinitialization request |

## Verification
On every cycle, the assertions check the following:
- Outputs clear after a cycle with `fs_data` low.
- Once established, alignment holds.
- While aligned, every lane delay lies within one multi-frame and at least one lane shows zero.
- A misalignment error can only appear after alignment.
- The error flags are sticky.

Only the bench scenarios can show the remaining behaviour. These are the exact rise cycle of `align_done` against the latest arrival, and the delay value of each lane for a given skew. They also cover the boundary between a span of `mf_len` and `mf_len`+1, and whether a single out-of-place character is caught.

// File: rtl/lane_align_mon.sv
module lane_align_mon #(
  parameter int NUM_LANES = 4,
  parameter int MF_W      = 8,
  localparam int TS_W     = MF_W + 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_LANES*8-1:0]    rx_octet,
  input  logic [NUM_LANES-1:0]      rx_ctrl,
  input  logic [NUM_LANES-1:0]      rx_vld,
  input  logic                      fs_data,
  input  logic [MF_W-1:0]           mf_len,
  output logic [NUM_LANES-1:0]      buf_rel,
  output logic [NUM_LANES*TS_W-1:0] lane_dly,
  output logic                      align_done,
  output logic                      err_skew,
  output logic                      err_misalign,
  output logic                      sync_req
);
  localparam logic [7:0] K_EOMF = 8'h7C;

  logic [TS_W-1:0]      ts, first_ts, last_ts, span;
  logic [NUM_LANES-1:0] seen, hit, mis_lane;
  logic [TS_W-1:0]      arr_ts [NUM_LANES];
  logic [MF_W-1:0]      ph     [NUM_LANES];
  logic [MF_W-1:0]      mf_last;
  logic                 all_seen, any_seen, new_hit, span_over;

  assign mf_last    = mf_len - 1'b1;
  assign all_seen   = &seen;
  assign any_seen   = |seen;
  assign new_hit    = |(hit & ~seen);
  assign span       = ts - first_ts;
  assign span_over  = any_seen & ~all_seen & (span > TS_W'(mf_len));
  assign align_done = all_seen & ~err_skew;
  assign buf_rel    = {NUM_LANES{align_done}};
  assign sync_req   = err_skew | err_misalign;

  for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
    assign hit[i] = fs_data & rx_vld[i] & rx_ctrl[i] & (rx_octet[i*8 +: 8] == K_EOMF);
    assign mis_lane[i] = hit[i] & seen[i] & (ph[i] != mf_last);
    assign lane_dly[i*TS_W +: TS_W] = align_done ? (last_ts - arr_ts[i]) : '0;

    always_ff @(posedge clk) begin
      if (!rst_n || !fs_data) begin
        seen[i]   <= 1'b0;
        arr_ts[i] <= '0;
        ph[i]     <= '0;
      end else if (hit[i] && !seen[i]) begin
        seen[i]   <= 1'b1;
        arr_ts[i] <= ts;
        ph[i]     <= '0;
      end else if (seen[i] && rx_vld[i]) begin
        ph[i] <= (ph[i] == mf_last) ? '0 : ph[i] + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !fs_data) begin
      ts           <= '0;
      first_ts     <= '0;
      last_ts      <= '0;
      err_skew     <= 1'b0;
      err_misalign <= 1'b0;
    end else begin
      ts <= ts + 1'b1;
      if (new_hit) begin
        if (!any_seen) first_ts <= ts;
        last_ts <= ts;
      end
      if (span_over) err_skew <= 1'b1;
      if (align_done && |mis_lane) err_misalign <= 1'b1;
    end
  end
endmodule

module lane_align_mon_chk #(
  parameter int NUM_LANES = 4,
  parameter int MF_W      = 8,
  localparam int TS_W     = MF_W + 2
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      fs_data,
  input logic [MF_W-1:0]           mf_len,
  input logic [NUM_LANES*TS_W-1:0] lane_dly,
  input logic                      align_done,
  input logic                      err_skew,
  input logic                      err_misalign,
  input logic                      sync_req
);
  logic [NUM_LANES-1:0] zero_d;

  for (genvar i = 0; i < NUM_LANES; i++) begin : g_c
    assign zero_d[i] = (lane_dly[i*TS_W +: TS_W] == '0);
    AST_DLY_WITHIN_MF: assert property (@(posedge clk) disable iff (!rst_n)
      align_done |-> (lane_dly[i*TS_W +: TS_W] <= TS_W'(mf_len))); // R5
  end

  AST_CLEAR_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !fs_data |=> (!align_done && !sync_req)); // R1
  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (fs_data && align_done) |=> align_done); // R3
  AST_LATEST_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    align_done |-> (zero_d != '0)); // R4
  AST_MIS_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_misalign) |-> $past(align_done)); // R6
  AST_SKEW_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (fs_data && err_skew) |=> err_skew); // R7
  AST_MIS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (fs_data && err_misalign) |=> err_misalign); // R7
endmodule

bind lane_align_mon lane_align_mon_chk #(.NUM_LANES(NUM_LANES), .MF_W(MF_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .fs_data(fs_data), .mf_len(mf_len),
  .lane_dly(lane_dly), .align_done(align_done), .err_skew(err_skew),
  .err_misalign(err_misalign), .sync_req(sync_req)
);

// File: tb/sim_lane_align_mon.sv
`timescale 1ns/1ps
module sim_lane_align_mon;
  localparam int NL = 4;
  localparam int MW = 8;
  localparam int TW = MW + 2;

  logic clk = 1'b0, rst_n = 1'b0, fs_data = 1'b0;
  logic [NL*8-1:0] rx_octet = '0;
  logic [NL-1:0] rx_ctrl = '0, rx_vld = '0, buf_rel;
  logic [MW-1:0] mf_len = 8'd4;
  logic [NL*TW-1:0] lane_dly;
  logic align_done, err_skew, err_misalign, sync_req;
  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  lane_align_mon #(.NUM_LANES(NL), .MF_W(MW)) u0 (
    .clk(clk), .rst_n(rst_n), .rx_octet(rx_octet), .rx_ctrl(rx_ctrl), .rx_vld(rx_vld),
    .fs_data(fs_data), .mf_len(mf_len), .buf_rel(buf_rel), .lane_dly(lane_dly),
    .align_done(align_done), .err_skew(err_skew), .err_misalign(err_misalign),
    .sync_req(sync_req));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic run_case(input int mf, input int s, input bit inj, input bit alt);
    int off[NL];
    int smax, total, cinj;
    bit skew;
    off[0] = s / 2; off[1] = 0; off[2] = s; off[3] = (s > 0) ? s - 1 : 0;
    smax = s;
    skew = (smax > mf);
    total = smax + 3 * mf + 2;
    cinj = off[1] + ((smax - off[1]) / mf + 1) * mf + 1;
    mf_len = MW'(mf);
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      fs_data = 1'b0; rx_vld = '1; rx_ctrl = '1; rx_octet = {NL{8'h7C}};
    end
    @(negedge clk);
    chk(!align_done && !sync_req && buf_rel == '0 && !err_skew && !err_misalign,
        "R1 cleared while fs_data low", {align_done, sync_req}, 0);
    chk(!err_skew && !err_misalign, "R7 flags cleared by fs_data low", {err_skew, err_misalign}, 0);
    for (int c = 0; c < total; c++) begin
      if (c != 0) @(negedge clk);
      if (c == smax && smax > 0)
        chk(align_done == 1'b0, "R3 not done before latest arrival", align_done, 0);
      if (c == smax + 1)
        chk(align_done == !skew, "R3 done right after latest arrival", align_done, !skew);
      fs_data = 1'b1;
      for (int l = 0; l < NL; l++) begin
        bit a;
        a = (c >= off[l] && ((c - off[l]) % mf) == 0) || (inj && !skew && l == 1 && c == cinj);
        rx_ctrl[l] = a;
        rx_octet[l*8 +: 8] = a ? 8'h7C : (alt ? 8'h7C : 8'(c));
      end
    end
    @(negedge clk);
    chk(err_skew == skew, $sformatf("R5 skew flag mf=%0d s=%0d", mf, s), err_skew, skew);
    chk(align_done == !skew, "R5 done blocked by skew", align_done, !skew);
    chk(buf_rel == (skew ? 4'h0 : 4'hF), "R3 buffer release", buf_rel, skew ? 0 : 15);
    if (!skew)
      for (int l = 0; l < NL; l++)
        chk(lane_dly[l*TW +: TW] == TW'(smax - off[l]),
            $sformatf("R4/R2 lane %0d delay mf=%0d s=%0d", l, mf, s),
            lane_dly[l*TW +: TW], smax - off[l]);
    chk(err_misalign == (inj && !skew), $sformatf("R6 misalign mf=%0d s=%0d", mf, s),
        err_misalign, inj && !skew);
    chk(sync_req == (skew || inj), "R7 sync request", sync_req, skew || inj);
  endtask

  initial begin
    rx_vld = '1;
    repeat (4) @(negedge clk);
    chk(!align_done && !sync_req && buf_rel == '0 && lane_dly == '0,
        "R1 reset state", align_done, 0);
    rst_n = 1'b1;
    foreach (mf_set[k]) ;
    for (int k = 0; k < 3; k++) begin
      int mf;
      mf = (k == 0) ? 2 : (k == 1) ? 5 : 8;
      for (int s = 0; s <= mf + 2; s++)
        run_case(mf, s, bit'(s % 2), bit'((s / 2) % 2));
    end
    @(negedge clk);
    fs_data = 1'b0;
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  int mf_set[1];

  initial begin
    #500us;
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule